// File: doc/BRIEF.md
# Read-after-write interlock for a five-stage pipeline without forwarding

This block decides, every cycle, whether the instruction sitting in the decode/register-read stage may move on to the ALU stage. The pipeline has five stages: fetch, decode/register-read, ALU, data memory, and register write. There is no operand forwarding, so a consumer has to wait until its producer's result is in the register file. The block compares both source register numbers of the decode instruction with the destination of each older instruction that is still in flight. If any live producer has not yet reached register write, the block raises a stall.

The register file writes in the first half of a cycle and reads in the second half. A consumer can therefore leave decode in the same cycle that its producer is in register write. Only producers in the ALU and data-memory stages block it. When the block stalls, it holds the fetch and decode stages in place and tells the ALU stage to load a bubble, with both the valid and write-enable bits cleared. The instructions in the memory and write-back stages keep moving. A consumer directly behind its producer therefore loses two cycles. The block is purely combinational and sits between the stage registers of the datapath.

Top module: `rdhaz_interlock`

## Requirements
- R1: When the ALU-stage instruction is valid, has write-enable set, has a non-zero destination, and that destination equals a decode source register, all three stall outputs are 1 in that cycle.
- R2: A valid, writing, non-zero destination in the data-memory stage that equals a decode source raises the stall outputs.
- R3: A match with an instruction in the register-write stage alone does not stall, because its write lands before the read in the same cycle.
- R4: A destination of register 0 never causes a stall, even when a source register is also 0.
- R5: A stage whose write-enable is 0, or whose valid bit is 0, never causes a stall.
- R6: The two source registers are compared independently, and a match on the second source alone is enough to stall.
- R7: `pc_hold`, `ifid_hold` and `ex_bubble` always carry the same value: 1 for a stall and 0 otherwise.
- R8: Instructions with no register overlap each spend exactly one cycle in decode, with no bubbles.
- R9: A consumer that directly follows its producer stays in decode for three consecutive cycles, with two stall cycles. A consumer two slots behind its producer stays in decode for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | RW | First source register of the decode instruction |
| id_rs2 | input | RW | Second source register of the decode instruction |
| ex_valid | input | 1 | ALU stage holds a real instruction |
| ex_we | input | 1 | ALU-stage instruction writes a register |
| ex_rd | input | RW | ALU-stage destination register |
| mem_valid | input | 1 | Data-memory stage holds a real instruction |
| mem_we | input | 1 | Data-memory-stage instruction writes a register |
| mem_rd | input | RW | Data-memory-stage destination register |
| wb_valid | input | 1 | Register-write stage holds a real instruction |
| wb_we | input | 1 | Register-write-stage instruction writes a register |
| wb_rd | input | RW | Register-write-stage destination register |
| pc_hold | output | 1 | Keep the fetch stage and program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ex_bubble | output | 1 | Load a bubble into the ALU stage instead of the decode instruction |

## Verification
A wrong comparison or a wrong stage mask shows at the stall outputs in the same cycle as the offending inputs, because the block holds no state. Two kinds of error are possible. A missed stall lets a consumer leave decode one or two cycles early, so it would read a stale register. A spurious stall, caused by a register-write-stage match, a zero destination or a non-writing stage, adds a decode cycle. The closed-loop pipeline model turns both kinds of error into a decode occupancy count that differs from the expected value for the affected instruction.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    // Stage positions behind decode, oldest last.
    typedef enum int unsigned {
        STG_ALU = 0,
        STG_MEM = 1,
        STG_WB  = 2
    } stage_e;

    localparam int unsigned NUM_STG = 3;

    // A stage can produce a value only if it holds a real, writing instruction
    // whose destination is not the hard-wired zero register.
    function automatic logic live_writer(input logic vld, input logic we, input logic rd_nonzero);
        return vld & we & rd_nonzero;
    endfunction

    // Stages whose pending write is not yet visible to a decode read.
    function automatic logic [NUM_STG-1:0] blocking_mask(input bit split_rf);
        logic [NUM_STG-1:0] m;
        m = '1;
        if (split_rf) m[STG_WB] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/hz_stage_cmp.sv
module hz_stage_cmp #(
    parameter int unsigned RW = 5
) (
    input  logic          vld,
    input  logic          we,
    input  logic [RW-1:0] rd,
    input  logic [RW-1:0] rs_a,
    input  logic [RW-1:0] rs_b,
    output logic          hit_a,
    output logic          hit_b
);
    logic live;

    always_comb begin
        live  = ilk_pkg::live_writer(vld, we, |rd);
        hit_a = live && (rd == rs_a);
        hit_b = live && (rd == rs_b);
    end

    // R4: a zero destination never produces a hit.
    always_comb begin
        if (rd == '0) begin
            p_zero_dst_r4: assert (!hit_a && !hit_b);
        end
    end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
    parameter int unsigned NUM_STG  = 3,
    parameter bit          SPLIT_RF = 1'b1
) (
    input  logic [NUM_STG-1:0] hit_a,
    input  logic [NUM_STG-1:0] hit_b,
    output logic               pc_hold,
    output logic               ifid_hold,
    output logic               ex_bubble
);
    localparam logic [NUM_STG-1:0] MASK = ilk_pkg::blocking_mask(SPLIT_RF);

    logic stall;

    always_comb begin
        stall     = |((hit_a | hit_b) & MASK);
        pc_hold   = stall;
        ifid_hold = stall;
        ex_bubble = stall;
    end
endmodule

// File: rtl/rdhaz_interlock.sv
module rdhaz_interlock #(
    parameter int unsigned RW       = 5,
    parameter bit          SPLIT_RF = 1'b1
) (
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic          ex_valid,
    input  logic          ex_we,
    input  logic [RW-1:0] ex_rd,
    input  logic          mem_valid,
    input  logic          mem_we,
    input  logic [RW-1:0] mem_rd,
    input  logic          wb_valid,
    input  logic          wb_we,
    input  logic [RW-1:0] wb_rd,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          ex_bubble
);
    import ilk_pkg::*;

    localparam int unsigned NS = NUM_STG;

    logic [NS-1:0]         st_vld;
    logic [NS-1:0]         st_we;
    logic [NS-1:0][RW-1:0] st_rd;
    logic [NS-1:0]         hit_a;
    logic [NS-1:0]         hit_b;

    always_comb begin
        st_vld[STG_ALU] = ex_valid;  st_we[STG_ALU] = ex_we;  st_rd[STG_ALU] = ex_rd;
        st_vld[STG_MEM] = mem_valid; st_we[STG_MEM] = mem_we; st_rd[STG_MEM] = mem_rd;
        st_vld[STG_WB]  = wb_valid;  st_we[STG_WB]  = wb_we;  st_rd[STG_WB]  = wb_rd;
    end

    for (genvar s = 0; s < NS; s++) begin : g_cmp
        hz_stage_cmp #(.RW(RW)) u_cmp (
            .vld   (st_vld[s]),
            .we    (st_we[s]),
            .rd    (st_rd[s]),
            .rs_a  (id_rs1),
            .rs_b  (id_rs2),
            .hit_a (hit_a[s]),
            .hit_b (hit_b[s])
        );
    end

    hz_ctrl #(.NUM_STG(NS), .SPLIT_RF(SPLIT_RF)) u_ctrl (
        .hit_a     (hit_a),
        .hit_b     (hit_b),
        .pc_hold   (pc_hold),
        .ifid_hold (ifid_hold),
        .ex_bubble (ex_bubble)
    );

    // Port-level checks on the comparator/control split.
    always_comb begin
        if (ex_valid && ex_we && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2)) begin
            p_alu_hit_stalls_r1: assert (pc_hold && ex_bubble);
        end
        if (mem_valid && mem_we && mem_rd != '0 && mem_rd == id_rs2) begin
            p_mem_src2_stalls_r6: assert (ifid_hold);
        end
        if (SPLIT_RF && !(ex_valid && ex_we) && !(mem_valid && mem_we)) begin
            p_wb_never_blocks_r3: assert (!pc_hold && !ifid_hold && !ex_bubble);
        end
        if (!ex_we && !mem_we && !wb_we) begin
            p_no_writer_free_r5: assert (!ex_bubble);
        end
        if (pc_hold == 1'b1 || pc_hold == 1'b0) begin
            p_outputs_agree_r7: assert (pc_hold == ifid_hold && ifid_hold == ex_bubble);
        end
    end
endmodule

// File: tb/rdhaz_interlock_test.sv
module rdhaz_interlock_test;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 5;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [RW-1:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
    logic ex_valid, ex_we, mem_valid, mem_we, wb_valid, wb_we;
    logic pc_hold, ifid_hold, ex_bubble;

    rdhaz_interlock #(.RW(RW)) uut (
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_valid(ex_valid), .ex_we(ex_we), .ex_rd(ex_rd),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_rd(mem_rd),
        .wb_valid(wb_valid), .wb_we(wb_we), .wb_rd(wb_rd),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ex_bubble(ex_bubble)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  stall;
        string req;
    } exp_t;
    exp_t sbq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: apply one vector at the falling edge and queue the expected result.
    task automatic drive(input int rs1, input int rs2,
                         input bit ev, input bit ew, input int er,
                         input bit mv, input bit mw, input int mr,
                         input bit wv, input bit ww, input int wr,
                         input logic stall, input string req);
        exp_t e;
        @(negedge clk);
        id_rs1 = RW'(rs1); id_rs2 = RW'(rs2);
        ex_valid = ev;  ex_we = ew;  ex_rd = RW'(er);
        mem_valid = mv; mem_we = mw; mem_rd = RW'(mr);
        wb_valid = wv;  wb_we = ww;  wb_rd = RW'(wr);
        e.stall = stall; e.req = req;
        sbq.push_back(e);
    endtask

    // Monitor: compare just after the rising edge, while inputs are still stable.
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check(pc_hold === e.stall, e.req, int'(pc_hold), int'(e.stall));
            check(ifid_hold === e.stall && ex_bubble === e.stall, {e.req, "/R7"},
                  int'({ifid_hold, ex_bubble}), e.stall ? 3 : 0);
        end
    end

    // Closed-loop pipeline model: counts decode cycles per instruction.
    int p_rd[8], p_s1[8], p_s2[8], occ[8];

    task automatic run_prog(input int n);
        int if_i, id_i, ex_i, mem_i, wb_i;
        bit st;
        if_i = 0; id_i = -1; ex_i = -1; mem_i = -1; wb_i = -1;
        for (int k = 0; k < 8; k++) occ[k] = 0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            @(negedge clk);
            id_rs1 = (id_i >= 0) ? RW'(p_s1[id_i]) : '0;
            id_rs2 = (id_i >= 0) ? RW'(p_s2[id_i]) : '0;
            ex_valid  = (ex_i >= 0);  ex_we  = (ex_i >= 0);  ex_rd  = (ex_i >= 0)  ? RW'(p_rd[ex_i])  : '0;
            mem_valid = (mem_i >= 0); mem_we = (mem_i >= 0); mem_rd = (mem_i >= 0) ? RW'(p_rd[mem_i]) : '0;
            wb_valid  = (wb_i >= 0);  wb_we  = (wb_i >= 0);  wb_rd  = (wb_i >= 0)  ? RW'(p_rd[wb_i])  : '0;
            #1;
            st = pc_hold;
            if (id_i >= 0) occ[id_i]++;
            wb_i = mem_i;
            mem_i = ex_i;
            if (st) ex_i = -1;
            else begin
                ex_i = id_i;
                id_i = if_i;
                if_i = (if_i >= 0 && if_i < n-1) ? if_i + 1 : -1;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        id_rs1 = '0; id_rs2 = '0;
        ex_valid = 0; ex_we = 0; ex_rd = '0;
        mem_valid = 0; mem_we = 0; mem_rd = '0;
        wb_valid = 0; wb_we = 0; wb_rd = '0;

        // Idle pipeline: no stall (R5, empty stages)
        drive(1, 2, 0,0,0, 0,0,0, 0,0,0, 1'b0, "R5 idle");
        drive(3, 4, 1,1,3, 0,0,0, 0,0,0, 1'b1, "R1 alu src1");
        drive(4, 9, 0,0,0, 1,1,9, 0,0,0, 1'b1, "R2 mem src2");
        drive(7, 8, 0,0,0, 0,0,0, 1,1,7, 1'b0, "R3 wb only");
        drive(0, 0, 1,1,0, 1,1,0, 1,1,0, 1'b0, "R4 zero dst");
        drive(6, 6, 1,0,6, 1,0,6, 0,0,0, 1'b0, "R5 we low");
        drive(6, 6, 0,1,6, 0,1,6, 0,0,0, 1'b0, "R5 valid low");
        drive(1, 12, 1,1,12, 0,0,0, 0,0,0, 1'b1, "R6 alu src2");
        drive(12, 1, 0,0,0, 1,1,12, 1,1,1, 1'b1, "R6 mem src1");
        drive(10, 11, 1,1,20, 1,1,21, 1,1,10, 1'b0, "R8 no overlap");
        @(negedge clk);
        @(negedge clk);

        // R9: consumer right behind producer
        p_rd[0] = 3; p_s1[0] = 1; p_s2[0] = 2;
        p_rd[1] = 5; p_s1[1] = 3; p_s2[1] = 4;
        run_prog(2);
        check(occ[0] == 1, "R9 producer decode cycles", occ[0], 1);
        check(occ[1] == 3, "R9 adjacent consumer decode cycles", occ[1], 3);

        // R8: independent stream
        p_rd[0] = 10; p_s1[0] = 1; p_s2[0] = 2;
        p_rd[1] = 11; p_s1[1] = 3; p_s2[1] = 4;
        p_rd[2] = 12; p_s1[2] = 5; p_s2[2] = 6;
        run_prog(3);
        check(occ[0] + occ[1] + occ[2] == 3, "R8 independent decode cycles", occ[0]+occ[1]+occ[2], 3);

        // R4: producer of register 0 with a reader of register 0
        p_rd[0] = 0; p_s1[0] = 1; p_s2[0] = 2;
        p_rd[1] = 4; p_s1[1] = 0; p_s2[1] = 0;
        run_prog(2);
        check(occ[1] == 1, "R4 zero-reg consumer decode cycles", occ[1], 1);

        // R9/R6: consumer two slots behind, matching on second source
        p_rd[0] = 6; p_s1[0] = 1; p_s2[0] = 2;
        p_rd[1] = 7; p_s1[1] = 1; p_s2[1] = 2;
        p_rd[2] = 8; p_s1[2] = 3; p_s2[2] = 6;
        run_prog(3);
        check(occ[2] == 2, "R9 distance-two consumer decode cycles (R6)", occ[2], 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule